// File: doc/BRIEF.md
# Radio-State GPIO Bank

This block owns a bank of general-purpose pins next to a radio. Each pin is either driven by software through a manual value register or switched automatically by the radio's live transmit/receive status. Four state registers hold the pin pattern for the idle, receive-only, transmit-only and full-duplex conditions. The two status inputs pick one of those patterns every cycle, with no software involvement. Pins configured as automatic take their value from that pattern, and the rest take it from the manual register.

Software configures the bank through a small word-addressed write port. Every write carries a data word and a bit mask. A separate combinational read port returns any register, including a readback word. The readback word holds the synchronized pad input levels, with the pins that are configured as outputs masked to zero. The bank width is a parameter. The default is 12 pins, and 6-pin and 8-pin builds are expected.

Register addresses: 0 pin mode (1 = automatic), 1 direction (1 = output), 2 manual value, 3 idle pattern, 4 receive-only pattern, 5 transmit-only pattern, 6 full-duplex pattern, 7 input readback (read-only).

Top module: `radio_gpio_bank`

## Requirements
- R1: After reset every register at addresses 0 to 6 reads 0, `padOe` is 0 and `padOut` is 0, so every pin is a manual input driving 0.
- R2: A write to addresses 0 to 6 updates only the register bits whose `wrMask` bit is 1. All other bits keep their value, and the new contents read back from the following cycle.
- R3: `padOe` equals the direction register (address 1). A 1 bit enables the pin's output driver, and the change is visible right after the write edge.
- R4: A pin whose mode bit (address 0) is 0 drives the value of its bit in the manual value register (address 2) on `padOut`.
- R5: A pin whose mode bit is 1 drives its bit of the pattern register chosen by {`txActive`,`rxActive`}: 00 selects address 3, 01 selects address 4, 10 selects address 5 and 11 selects address 6.
- R6: `padOut` is registered. A change of status, mode or value shows on `padOut` at the first clock edge after it, and not before that edge.
- R7: Writing the manual value register has no effect on `padOut` bits of pins in automatic mode.
- R8: `padIn` passes through two flip-flop stages. A level change appears in the readback word (address 7) after the second clock edge. Readback bits of pins whose direction bit is 1 read 0.
- R9: Writes to address 7 are ignored. No configuration register changes, and readback still shows only pad levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write word address |
| wrData | input | PINS | Write value |
| wrMask | input | PINS | Write bit mask, 1 = update bit |
| rdAddr | input | 3 | Register read word address |
| rdData | output | PINS | Read value (combinational) |
| txActive | input | 1 | Radio transmitting |
| rxActive | input | 1 | Radio receiving |
| padIn | input | PINS | Pad input levels (asynchronous) |
| padOut | output | PINS | Pad drive value |
| padOe | output | PINS | Pad output enable |

## Verification
A corrupted configuration bit shows at the ports within one cycle. A direction error shows on `padOe` immediately after the write edge. A mode or pattern error shows on `padOut` after the next edge, and the read port exposes every register in the same cycle. A wrong state-select decode shows only when the bench drives the status combination that reaches the affected pattern, so all four {tx,rx} codes are stepped with distinct patterns in every register. A synchronizer with too few or too many stages shifts the readback change by one edge, so the bench samples readback after both the first and the second edge.

// File: rtl/radio_gpio_pkg.sv
package radio_gpio_pkg;
  localparam int ADDR_W   = 3;
  localparam int NUM_CFG  = 7;   // writable registers at addresses 0..6
  localparam int A_MODE   = 0;
  localparam int A_DIR    = 1;
  localparam int A_MANUAL = 2;
  localparam int A_IDLE   = 3;   // patterns follow in {tx,rx} order
  localparam int A_RDBK   = 7;

  typedef struct packed {
    logic [NUM_CFG-1:0] wrHit;     // one-hot register update strobe
    logic [1:0]         stateSel;  // {tx, rx}
  } ctrlStrobes_t;
endpackage

// File: rtl/rgb_ctrl.sv
module rgb_ctrl
  import radio_gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              txActive,
  input  logic              rxActive,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes.wrHit    = '0;
    strobes.stateSel = {txActive, rxActive};
    for (int i = 0; i < NUM_CFG; i++) begin
      if (wrEn && (int'(wrAddr) == i)) strobes.wrHit[i] = 1'b1;
    end
  end

  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrHit));
  a_r9_readback_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(wrAddr) == A_RDBK) |-> (strobes.wrHit == '0));
endmodule

// File: rtl/rgb_datapath.sv
module rgb_datapath
  import radio_gpio_pkg::*;
#(
  parameter int PINS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [PINS-1:0]   wrData,
  input  logic [PINS-1:0]   wrMask,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [PINS-1:0]   rdData,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe
);
  logic [PINS-1:0] cfg [NUM_CFG];
  logic [PINS-1:0] syncA, syncB;
  logic [PINS-1:0] pattern, nextOut, readback;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 cfg[g] <= '0;
      else if (strobes.wrHit[g]) cfg[g] <= (cfg[g] & ~wrMask) | (wrData & wrMask);
    end

    a_r2_masked_update: assert property (@(posedge clk) disable iff (!rstN)
      strobes.wrHit[g] |=> ((cfg[g] & ~$past(wrMask)) == ($past(cfg[g]) & ~$past(wrMask)))
                        && ((cfg[g] & $past(wrMask)) == ($past(wrData) & $past(wrMask))));
    a_r2_hold_unwritten: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.wrHit[g] |=> $stable(cfg[g]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      padOut <= '0;
    end else begin
      syncA  <= padIn;
      syncB  <= syncA;
      padOut <= nextOut;
    end
  end

  always_comb begin
    pattern  = cfg[A_IDLE + int'(strobes.stateSel)];
    nextOut  = (cfg[A_MODE] & pattern) | (~cfg[A_MODE] & cfg[A_MANUAL]);
    readback = syncB & ~cfg[A_DIR];
    padOe    = cfg[A_DIR];
  end

  always_comb begin
    case (rdAddr)
      3'd0:    rdData = cfg[0];
      3'd1:    rdData = cfg[1];
      3'd2:    rdData = cfg[2];
      3'd3:    rdData = cfg[3];
      3'd4:    rdData = cfg[4];
      3'd5:    rdData = cfg[5];
      3'd6:    rdData = cfg[6];
      default: rdData = readback;
    endcase
  end

  a_r7_manual_write_spares_auto: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrHit[A_MANUAL] && $stable(strobes.stateSel) && !strobes.wrHit[A_MODE]
     && (strobes.wrHit & ~(NUM_CFG'(1) << A_MANUAL)) == '0)
    |=> ##1 ((padOut & cfg[A_MODE]) == ($past(padOut) & cfg[A_MODE]))
            || !$stable(strobes.stateSel) || (strobes.wrHit != '0) || ($past(strobes.wrHit) != '0));
endmodule

// File: rtl/radio_gpio_bank.sv
module radio_gpio_bank
  import radio_gpio_pkg::*;
#(
  parameter int PINS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PINS-1:0]   wrData,
  input  logic [PINS-1:0]   wrMask,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [PINS-1:0]   rdData,
  input  logic              txActive,
  input  logic              rxActive,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe
);
  ctrlStrobes_t strobes;

  rgb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .txActive(txActive), .rxActive(rxActive), .strobes(strobes)
  );

  rgb_datapath #(.PINS(PINS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .wrMask(wrMask),
    .rdAddr(rdAddr), .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  a_r8_outputs_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdAddr) == A_RDBK) |-> ((rdData & padOe) == '0));
  a_r3_oe_after_dir_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(wrAddr) == A_DIR)
    |=> (padOe == (($past(padOe) & ~$past(wrMask)) | ($past(wrData) & $past(wrMask)))));
endmodule

// File: tb/radio_gpio_bank_tb.sv
module radio_gpio_bank_tb;
  localparam int PINS = 12;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [PINS-1:0] wrData = '0, wrMask = '0;
  logic [2:0] rdAddr = '0;
  logic [PINS-1:0] rdData;
  logic txActive = 1'b0, rxActive = 1'b0;
  logic [PINS-1:0] padIn = '0;
  logic [PINS-1:0] padOut, padOe;
  int checks = 0, errors = 0;
  bit done = 0;

  // model of the register contents as written by the bench
  logic [PINS-1:0] mMode, mDir, mManual;
  logic [PINS-1:0] mPat [4];

  always #2.5 clk = ~clk;

  radio_gpio_bank #(.PINS(PINS)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrMask(wrMask), .rdAddr(rdAddr), .rdData(rdData), .txActive(txActive),
    .rxActive(rxActive), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string req, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [PINS-1:0] d, input logic [PINS-1:0] m);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrMask = m;
    @(negedge clk);
    wrEn = 1'b0; wrMask = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [PINS-1:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  function automatic logic [PINS-1:0] expOut(input int s);
    return (mMode & mPat[s]) | (~mMode & mManual);
  endfunction

  task automatic t_reset();
    logic [PINS-1:0] v;
    check("R1 padOe", padOe, '0);
    check("R1 padOut", padOut, '0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 register", v, '0);
    end
  endtask

  task automatic t_masked();
    logic [PINS-1:0] v;
    wr(3'd0, 12'hFFF, 12'h0F0);
    rd(3'd0, v); check("R2 set masked", v, 12'h0F0);
    wr(3'd0, 12'h000, 12'h030);
    rd(3'd0, v); check("R2 clear masked", v, 12'h0C0);
    wr(3'd0, 12'h000, 12'hFFF);
    rd(3'd0, v); check("R2 full clear", v, 12'h000);
  endtask

  task automatic t_direction();
    wr(3'd1, 12'hA5A, 12'hFFF);
    check("R3 oe full write", padOe, 12'hA5A);
    wr(3'd1, 12'h0F0, 12'h00F);
    check("R3 oe masked write", padOe, 12'hA50);
    mDir = 12'hA50;
  endtask

  task automatic t_manual();
    wr(3'd2, 12'h3C3, 12'hFFF);
    mManual = 12'h3C3;
    check("R6 manual not before edge", padOut, 12'h000);
    @(negedge clk);
    check("R4 manual drive", padOut, 12'h3C3);
  endtask

  task automatic t_states();
    logic [PINS-1:0] prev;
    wr(3'd3, 12'h111, 12'hFFF); mPat[0] = 12'h111;
    wr(3'd4, 12'h222, 12'hFFF); mPat[1] = 12'h222;
    wr(3'd5, 12'h444, 12'hFFF); mPat[2] = 12'h444;
    wr(3'd6, 12'h888, 12'hFFF); mPat[3] = 12'h888;
    wr(3'd0, 12'h00F, 12'hFFF); mMode = 12'h00F;
    @(negedge clk);
    check("R5 idle pattern", padOut, expOut(0));
    prev = padOut;
    for (int s = 1; s < 4; s++) begin
      txActive = s[1]; rxActive = s[0];
      #1;
      check("R6 state not before edge", padOut, prev);
      @(negedge clk);
      check("R5 state pattern", padOut, expOut(s));
      prev = padOut;
    end
    check("R5 full-duplex value", padOut, 12'h3C8);
  endtask

  task automatic t_override();
    txActive = 1'b1; rxActive = 1'b0;
    @(negedge clk);
    wr(3'd2, 12'hFFF, 12'hFFF); mManual = 12'hFFF;
    @(negedge clk);
    check("R7 auto pins untouched", padOut & mMode, 12'h004);
    check("R4 manual pins updated", padOut, expOut(2));
  endtask

  task automatic t_ignore();
    logic [PINS-1:0] v;
    wr(3'd7, 12'hFFF, 12'hFFF);
    rd(3'd0, v); check("R9 mode kept", v, mMode);
    rd(3'd1, v); check("R9 dir kept", v, mDir);
    rd(3'd2, v); check("R9 manual kept", v, mManual);
    for (int s = 0; s < 4; s++) begin
      rd(3'(3 + s), v); check("R9 pattern kept", v, mPat[s]);
    end
    rd(3'd7, v); check("R9 readback unchanged", v, 12'h000);
  endtask

  task automatic t_readback();
    logic [PINS-1:0] v;
    @(negedge clk);
    padIn = 12'hFFF;
    @(negedge clk);
    rd(3'd7, v); check("R8 one edge still old", v, 12'h000);
    @(negedge clk);
    rd(3'd7, v); check("R8 after two edges", v, 12'hFFF & ~mDir);
    check("R8 outputs read zero", v & padOe, 12'h000);
    padIn = 12'h5A5;
    repeat (2) @(negedge clk);
    rd(3'd7, v); check("R8 second pattern", v, 12'h5A5 & ~mDir);
  endtask

  initial begin
    mMode = '0; mDir = '0; mManual = '0;
    for (int s = 0; s < 4; s++) mPat[s] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked();
    t_direction();
    t_manual();
    t_states();
    t_override();
    t_ignore();
    t_readback();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule